// File: doc/BRIEF.md
# Multi-Grant Round-Robin Output Scheduler

This block arbitrates for one output port of an input-buffered switch whose crossbar offers several parallel links into that output. Every clock cycle is one time slot. The block samples a request vector with one bit per input controller and grants up to `M` of those requests at once, where `M` is the number of crossbar links into this output. Grants come back one cycle later on an acknowledge vector, together with a per-input link index telling each winner which of the `M` links it may use.

Selection is round-robin. The search walks the inputs cyclically, starting from a priority pointer, and grants the first `M` requesting inputs it meets. When demand exceeds the link count, the pointer for the next slot lands on the first requester that was refused, so refused inputs come first in the next slot. When every request fits, the pointer moves to the position just after the last winner. An idle slot leaves the pointer where it was.

Top module: `msrr_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, no acknowledge bit is set; the priority pointer starts at input 0.
- R2: An acknowledge bit is set only for an input whose request bit was set in the previous cycle (one cycle from request to acknowledge).
- R3: The number of acknowledge bits set equals the smaller of `M` and the number of requests sampled in the previous cycle.
- R4: Granted inputs are the first `M` requesting inputs met when searching upward from the pointer, wrapping from input N-1 to input 0.
- R5: When more than `M` inputs request, the next slot's pointer is the first requesting input that was refused.
- R6: When between 1 and `M` inputs request, all are granted and the next pointer is the input after the last one granted in search order.
- R7: When no input requests, no acknowledge bit is set and the pointer is unchanged.
- R8: Each granted input receives a link index in its own `LW`-bit field of `link_id` (field i at bits i*LW upward); winners get 0, 1, ... up to M-1 in search order; the field of an ungranted input reads 0.
- R9: Pointer arithmetic wraps modulo N: after a last winner at input N-1 the pointer returns to input 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock; one cycle per time slot |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request vector, bit i from input controller i |
| ack | output | N | Acknowledge vector, bit i grants input i |
| link_id | output | N*LW | Per-input link index, LW = max(1, clog2(M)) bits each |

## Verification
The pointer update and the grant decision happen in the same cycle: the grants of a slot are computed from the pointer left by the previous slot, while that same slot writes the pointer for the next one. This is provoked by back-to-back slots that switch between overload, light load, idle and wrap-around patterns, so that each slot's expected grants and link indices are only right if the pointer rule (refused-first, after-last-winner, or hold) was applied in the cycle before. A reference pointer kept in the bench from the requirements predicts every slot, and the directed slots also compare against hand-computed acknowledge values.

// File: rtl/msrr_pkg.sv
package msrr_pkg;
   function automatic int unsigned bits_for(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) < n) w++;
      return w;
   endfunction
endpackage

// File: rtl/msrr_search.sv
module msrr_search #(
   parameter int unsigned N  = 8,
   parameter int unsigned M  = 2,
   parameter int unsigned PW = 3,
   parameter int unsigned LW = 1
) (
   input  logic [N-1:0]    req,
   input  logic [PW-1:0]   ptr,
   output logic [N-1:0]    grant,
   output logic [N*LW-1:0] link,
   output logic [PW-1:0]   ptr_next
);
   int unsigned cnt;
   int unsigned idx;
   int unsigned last;
   int unsigned refused;
   logic        found;

   always_comb begin
      grant   = '0;
      link    = '0;
      cnt     = 0;
      idx     = 0;
      last    = 0;
      refused = 0;
      found   = 1'b0;
      for (int unsigned k = 0; k < N; k++) begin
         idx = int'(ptr) + k;
         if (idx >= N) idx = idx - N;
         if (req[idx]) begin
            if (cnt < M) begin
               grant[idx]            = 1'b1;
               link[idx*LW +: LW]    = LW'(cnt);
               cnt                   = cnt + 1;
               last                  = idx;
            end else if (!found) begin
               found   = 1'b1;
               refused = idx;
            end
         end
      end
      if (found)
         ptr_next = PW'(refused);
      else if (cnt != 0)
         ptr_next = (last == N - 1) ? '0 : PW'(last + 1);
      else
         ptr_next = ptr;
   end
endmodule

// File: rtl/msrr_ptr.sv
module msrr_ptr #(
   parameter int unsigned N  = 8,
   parameter int unsigned PW = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          any_req,
   input  logic [PW-1:0] ptr_next,
   output logic [PW-1:0] ptr
);
   always_ff @(posedge clk) begin
      if (!rst_n) ptr <= '0;
      else        ptr <= ptr_next;
   end

   assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !any_req |=> $stable(ptr));
   assert_ptr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
      int'(ptr) < N);
endmodule

// File: rtl/msrr_sched.sv
module msrr_sched
   import msrr_pkg::*;
#(
   parameter int unsigned N       = 8,
   parameter int unsigned M       = 2,
   parameter bit          REG_OUT = 1'b1,
   localparam int unsigned PW     = bits_for(N),
   localparam int unsigned LW     = bits_for(M)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N-1:0]    req,
   output logic [N-1:0]    ack,
   output logic [N*LW-1:0] link_id
);
   initial begin
      assert (N >= 2) else $error("msrr_sched: N must be at least 2");
      assert (M >= 1 && M <= N) else $error("msrr_sched: M must lie in 1..N");
   end

   logic [PW-1:0]   ptr;
   logic [PW-1:0]   ptr_next;
   logic [N-1:0]    grant;
   logic [N*LW-1:0] link;

   msrr_search #(.N(N), .M(M), .PW(PW), .LW(LW)) u_search (
      .req      (req),
      .ptr      (ptr),
      .grant    (grant),
      .link     (link),
      .ptr_next (ptr_next)
   );

   msrr_ptr #(.N(N), .PW(PW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .any_req  (|req),
      .ptr_next (ptr_next),
      .ptr      (ptr)
   );

   generate
      if (REG_OUT) begin : g_reg
         logic armed;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               ack     <= '0;
               link_id <= '0;
               armed   <= 1'b0;
            end else begin
               ack     <= grant;
               link_id <= link;
               armed   <= 1'b1;
            end
         end

         assert_ack_subset_R2: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> ((ack & ~$past(req)) == '0));
         assert_ack_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> ($countones(ack) ==
               (($countones($past(req)) > M) ? M : $countones($past(req)))));
         assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(req) == '0) |-> (ack == '0));
         assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !armed |-> (ack == '0));
         for (genvar i = 0; i < N; i++) begin : g_lchk
            assert_link_field_R8: assert property (@(posedge clk) disable iff (!rst_n)
               ack[i] ? (int'(link_id[i*LW +: LW]) < M) : (link_id[i*LW +: LW] == '0));
         end
      end else begin : g_comb
         always_comb begin
            ack     = rst_n ? grant : '0;
            link_id = rst_n ? link  : '0;
         end
      end
   endgenerate
endmodule

// File: tb/sim_msrr_sched.sv
module sim_msrr_sched;
   localparam int N  = 8;
   localparam int M  = 2;
   localparam int LW = 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    req = '0;
   logic [N-1:0]    ack;
   logic [N*LW-1:0] link_id;

   int checks = 0;
   int errors = 0;
   int mptr   = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   msrr_sched #(.N(N), .M(M)) u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .ack(ack), .link_id(link_id)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Reference from the requirements: cyclic search from mptr, first M win.
   task automatic model(input logic [N-1:0] r, output logic [N-1:0] ea,
                        output logic [N*LW-1:0] el, output int np);
      int cnt = 0, last = 0, refd = -1;
      ea = '0; el = '0;
      for (int k = 0; k < N; k++) begin
         int i = (mptr + k) % N;
         if (r[i]) begin
            if (cnt < M) begin
               ea[i] = 1'b1; el[i*LW +: LW] = LW'(cnt); cnt++; last = i;
            end else if (refd < 0) refd = i;
         end
      end
      if (refd >= 0)     np = refd;          // R5
      else if (cnt > 0)  np = (last + 1) % N; // R6, R9
      else               np = mptr;          // R7
   endtask

   task automatic slot(input logic [N-1:0] r, input bit use_exp,
                       input logic [N-1:0] exp_ack, input string tag);
      logic [N-1:0]    ea;
      logic [N*LW-1:0] el;
      int np;
      model(r, ea, el, np);
      @(negedge clk) req = r;
      @(negedge clk);
      req = '0;
      if (use_exp)
         check(ack == exp_ack, {tag, " R4 ack"}, int'(ack), int'(exp_ack));
      check(ack == ea, {tag, " R3 ack-model"}, int'(ack), int'(ea));
      check(link_id == el, {tag, " R8 link"}, int'(link_id), int'(el));
      mptr = np;
   endtask

   task automatic t_reset;
      repeat (3) @(negedge clk);
      check(ack == '0, "R1 ack in reset", int'(ack), 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      check(ack == '0, "R1 ack after reset", int'(ack), 0);
      slot(8'hFF, 1'b1, 8'h03, "R1 pointer starts at 0");
   endtask

   task automatic t_light;
      slot(8'h20, 1'b1, 8'h20, "R6 single request");
      slot(8'h84, 1'b1, 8'h84, "R8 search order from 6");
   endtask

   task automatic t_idle;
      slot(8'h00, 1'b1, 8'h00, "R7 idle slot");
      slot(8'hFF, 1'b1, 8'h18, "R7 pointer held at 3");
   endtask

   task automatic t_overload;
      slot(8'hC1, 1'b1, 8'hC0, "R5 refused input 0");
      slot(8'h81, 1'b1, 8'h81, "R5 refused first served");
   endtask

   task automatic t_wrap;
      slot(8'h83, 1'b1, 8'h03, "R9 pointer wrapped to 0");
      slot(8'h81, 1'b1, 8'h81, "R9 start at 7 wraps to 0");
      slot(8'h01, 1'b1, 8'h01, "R9 pointer after wrap is 1");
   endtask

   task automatic t_sweep;
      logic [15:0] lfsr = 16'hACE1;
      for (int s = 0; s < 300; s++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         slot(lfsr[N-1:0] & lfsr[15:8], 1'b0, '0, "R2 sweep");
         check((ack & ~(lfsr[N-1:0] & lfsr[15:8])) == '0, "R2 ack subset",
               int'(ack), 0);
      end
   endtask

   initial begin
      t_reset();
      t_light();
      t_idle();
      t_overload();
      t_wrap();
      t_sweep();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule